// File: doc/BRIEF.md
# Eight-Line Addressable Latch with Decoder Mode

The block keeps eight single-bit storage cells and writes one of them at a time. A single data bit is steered to the cell picked by a 3-bit index. Two active-low controls, a write strobe and a wipe input, are taken together to pick one of four modes. In write mode the picked cell takes the data bit and the other cells keep their values. In hold mode nothing changes. In wipe mode all cells go low. In decode mode the picked cell takes the data bit and all the other cells go low, so the block acts as a 3-to-8 demultiplexer.

All storage is held in registers on a system clock, with an asynchronous reset. The output bus always shows the value that the cells will take at the next clock edge. While the strobe is active, the picked line is therefore transparent to the data bit in the same cycle. Whatever the output showed in the last strobe cycle stays stored once the strobe goes inactive. The index and the data bit should only change while the strobe is inactive.

Top module: `addr_latch8`

## Requirements
- R1: The index `sel` is a binary number with `sel[2]` as the most significant bit; index k addresses output bit `q[k]` (0 selects `q[0]`, 7 selects `q[7]`).
- R2: With `wipe_n`=1 and `wr_n`=0 (write mode), `q[sel]` equals `din` in the same cycle.
- R3: In write mode every output bit other than `q[sel]` keeps the value it had in the previous cycle.
- R4: The value shown on `q` in the last cycle with `wr_n`=0 is kept on `q` after `wr_n` returns to 1.
- R5: With `wipe_n`=1 and `wr_n`=1 (hold mode), `q` keeps its previous value whatever `din` and `sel` do.
- R6: With `wipe_n`=0 and `wr_n`=1 (wipe mode), `q` is all zero in that same cycle, and it stays zero in later hold cycles.
- R7: With `wipe_n`=0 and `wr_n`=0 (decode mode), `q[sel]` equals `din` and every other bit of `q` is 0; this pattern is kept once hold mode follows.
- R8: While `rst_n`=0 all storage is cleared, so `q` reads all zero in hold mode after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; storage updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all storage |
| din | input | 1 | Data bit steered to the addressed line |
| sel | input | 3 | Line index, bit 2 most significant |
| wr_n | input | 1 | Active-low write strobe |
| wipe_n | input | 1 | Active-low wipe; turns write into decode when `wr_n` is also low |
| q | output | 8 | Output lines, equal to the value each cell takes at the next edge |

## Verification
The bench walks a single bit through all eight index values. After each write it moves the index and the data while the strobe is inactive: a design with a swapped index bit order lights the wrong line, and one that ignores the strobe during hold overwrites the captured bit. Several data values are written to one line inside one strobe window. Only the last one must survive, which catches a design that captures on the first cycle. Decode mode is run over every index with both data values, and wipe mode is run on a full pattern. A design that keeps old bits in decode mode, or that does not blank the outputs until the next edge in wipe mode, shows stale ones on the bus.

// File: rtl/alatch_pkg.sv
package alatch_pkg;

    // Operating mode chosen by the pair {wipe_n, wr_n}
    typedef enum logic [1:0] {
        MODE_HOLD   = 2'b00,
        MODE_WRITE  = 2'b01,
        MODE_DECODE = 2'b10,
        MODE_WIPE   = 2'b11
    } alatch_mode_e;

endpackage

// File: rtl/alatch_mode_dec.sv
module alatch_mode_dec
    import alatch_pkg::*;
(
    input  logic         wr_n,
    input  logic         wipe_n,
    output alatch_mode_e mode
);

    always_comb begin
        unique case ({wipe_n, wr_n})
            2'b11:   mode = MODE_HOLD;
            2'b10:   mode = MODE_WRITE;
            2'b00:   mode = MODE_DECODE;
            default: mode = MODE_WIPE;
        endcase
    end

endmodule

// File: rtl/alatch_sel_dec.sv
module alatch_sel_dec #(
    parameter int ADDR_W = 3,
    localparam int LINES = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] sel,
    output logic [LINES-1:0]  hit
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign hit[i] = (sel == ADDR_W'(i));
    end

endmodule

// File: rtl/alatch_bank.sv
module alatch_bank
    import alatch_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  alatch_mode_e     mode,
    input  logic [LINES-1:0] hit,
    input  logic             din,
    output logic [LINES-1:0] bits_nxt
);

    typedef struct packed {
        logic [LINES-1:0] bits;
    } bank_t;

    bank_t st_d, st_q;
    logic [LINES-1:0] cell_nxt;

    for (genvar i = 0; i < LINES; i++) begin : g_cell
        logic keep_v;
        logic load_v;
        assign keep_v = st_q.bits[i];
        // picked cell loads data in write and decode modes
        assign load_v = hit[i] ? din : 1'b0;
        always_comb begin
            unique case (mode)
                MODE_HOLD:   cell_nxt[i] = keep_v;
                MODE_WRITE:  cell_nxt[i] = hit[i] ? din : keep_v;
                MODE_DECODE: cell_nxt[i] = load_v;
                default:     cell_nxt[i] = 1'b0;
            endcase
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = cell_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits_nxt = st_d.bits;

endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
    import alatch_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int LINES = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [ADDR_W-1:0] sel,
    input  logic              wr_n,
    input  logic              wipe_n,
    output logic [LINES-1:0]  q
);

    alatch_mode_e     mode;
    logic [LINES-1:0] hit;
    logic [LINES-1:0] bits_nxt;

    alatch_mode_dec u_mode (
        .wr_n   (wr_n),
        .wipe_n (wipe_n),
        .mode   (mode)
    );

    alatch_sel_dec #(.ADDR_W(ADDR_W)) u_sel (
        .sel (sel),
        .hit (hit)
    );

    alatch_bank #(.LINES(LINES)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .hit      (hit),
        .din      (din),
        .bits_nxt (bits_nxt)
    );

    // transparent view: the output is the value the cells take next
    assign q = bits_nxt;

endmodule

// File: rtl/addr_latch8_chk.sv
module addr_latch8_chk #(
    parameter int ADDR_W = 3,
    localparam int LINES = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              din,
    input logic [ADDR_W-1:0] sel,
    input logic              wr_n,
    input logic              wipe_n,
    input logic [LINES-1:0]  q
);

    logic             armed_q;
    logic [LINES-1:0] lmask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign lmask = LINES'(1) << sel;

    // R2
    write_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe_n && !wr_n) |-> (q[sel] == din));

    // R3
    write_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && wipe_n && !wr_n) |-> ((q & ~lmask) == ($past(q) & ~lmask)));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && wipe_n && wr_n) |-> (q == $past(q)));

    // R6
    wipe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wipe_n && wr_n) |-> (q == '0));

    // R7
    decode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wipe_n && !wr_n) |-> ($onehot0(q) && (q[sel] == din)));

endmodule

bind addr_latch8 addr_latch8_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (din),
    .sel    (sel),
    .wr_n   (wr_n),
    .wipe_n (wipe_n),
    .q      (q)
);

// File: tb/test_addr_latch8.sv
`timescale 1ns/1ps
module test_addr_latch8;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0;
    logic [2:0] sel = '0;
    logic       wr_n = 1'b1;
    logic       wipe_n = 1'b1;
    logic [7:0] q;

    sb_item_t   sb[$];
    logic [7:0] mstore = '0;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    addr_latch8 i_addr_latch8 (
        .clk(clk), .rst_n(rst_n), .din(din), .sel(sel),
        .wr_n(wr_n), .wipe_n(wipe_n), .q(q)
    );

    always #2.5 clk = ~clk;

    // reference model written from the requirements
    function automatic logic [7:0] model(input logic [7:0] st, input logic wp, input logic w,
                                         input logic [2:0] a, input logic d);
        logic [7:0] r;
        r = st;
        if (wp && !w)       r[a] = d;                  // write
        else if (!wp && !w) begin r = '0; r[a] = d; end // decode
        else if (!wp && w)  r = '0;                    // wipe
        return r;
    endfunction

    task automatic step(input logic wp, input logic w, input logic [2:0] a,
                        input logic d, input string tag);
        sb_item_t it;
        @(negedge clk);
        wipe_n = wp; wr_n = w; sel = a; din = d;
        it.exp = model(mstore, wp, w, a, d);
        it.tag = tag;
        mstore = it.exp;
        sb.push_back(it);
    endtask

    // monitor: compare after inputs settle, before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                sb_item_t it;
                it = sb.pop_front();
                checks++;
                if (q !== it.exp) begin
                    errors++;
                    $display("FAIL %s q=%08b expected=%08b", it.tag, q, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog q=%08b expected=finish", q);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: reset leaves all lines low
        step(1, 1, 3'd5, 1, "R8");
        step(1, 1, 3'd2, 0, "R8");

        // R1 R2 R3: walk each index, then move inputs during hold (R4 R5)
        for (int a = 0; a < 8; a++) begin
            step(1, 0, 3'(a), 1'(~a[0]), "R1_R2_R3");
            step(1, 1, 3'(7 - a), 1'(a[0]), "R4_R5");
            step(1, 1, 3'(a + 3), 1'b1, "R5");
        end

        // R4: last value of the window is the one kept
        step(1, 0, 3'd6, 1, "R2");
        step(1, 0, 3'd6, 0, "R2");
        step(1, 0, 3'd6, 1, "R2");
        step(1, 0, 3'd6, 0, "R4");
        step(1, 1, 3'd1, 1, "R4");
        step(1, 0, 3'd1, 1, "R3");
        step(1, 1, 3'd0, 0, "R4");

        // R6: wipe clears at once and stays clear
        step(1, 0, 3'd7, 1, "R3");
        step(0, 1, 3'd7, 1, "R6");
        step(1, 1, 3'd4, 1, "R6");
        step(1, 1, 3'd0, 0, "R6");

        // R7: decode over every index, both data values
        step(1, 0, 3'd3, 1, "R2");
        for (int a = 0; a < 8; a++) begin
            step(0, 0, 3'(a), 1'b1, "R7");
            step(0, 0, 3'(a), 1'b0, "R7");
        end
        step(0, 0, 3'd5, 1, "R7");
        step(1, 1, 3'd2, 0, "R7");
        step(1, 1, 3'd6, 1, "R7");

        // R8: reset mid-run clears a loaded pattern
        step(1, 0, 3'd0, 1, "R3");
        step(1, 1, 3'd0, 1, "R5");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mstore = '0;
        step(1, 1, 3'd0, 1, "R8");

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        #2;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule